// File: doc/BRIEF.md
# Width-Selectable Integer ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit load/store processor. Every operation names a width: full word, halfword or byte, and for the two narrow widths it also says whether the result is zero-extended or sign-extended to 32 bits. Both operands are cut down to the chosen width before the operation. The result is cut down again and extended as the width code says. The four condition flags are worked out at the chosen width, not at 32 bits.

Operand A always comes from a register. Operand B comes either from a second register or from a 16-bit instruction immediate, chosen by a select bit. The result and flags are captured into output registers on the cycle an execute strobe is high. They hold unchanged between strobes, so the decode logic can keep driving operand values without disturbing the captured state.

Top module: `narrow_alu`

## Requirements
- R1: After a synchronous active-high reset, `result_q` is 0 and all four flags are clear.
- R2: Result and flags update only on a clock edge where `exec_en` is 1, and then appear in the cycle after that edge. With `exec_en` at 0 they hold their value.
- R3: `width_code` encodings are: 0 = 32-bit word, 1 = 16-bit zero-extended, 2 = 16-bit sign-extended, 3 = 8-bit zero-extended, 4 = 8-bit sign-extended. Codes 5 to 7 behave as word.
- R4: At a narrow width, bits of either operand above the width have no effect. The result above the width is all zeros for the zero-extending codes and copies of the width's top bit for the sign-extending codes.
- R5: `op_code` encodings are: 0 = add, 1 = subtract (A minus B), 2 = AND, 3 = OR, 4 = XOR. Codes 5 to 7 pass operand A through at the chosen width.
- R6: With `imm_sel` at 1, operand B is `imm_val` sign-extended to 32 bits, then cut to the width. With `imm_sel` at 0, operand B is `src_b` and `imm_val` is ignored.
- R7: Z is set when the width-limited result is zero. N is the top bit of the width-limited result, whatever the extension mode.
- R8: C is the carry out of the top bit of the width for add. For subtract it is the borrow, set when A is below B unsigned at that width. V flags a signed overflow at that width for add and subtract.
- R9: The logic and pass-through codes leave C and V clear.
- R10: A byte subtract of 1 minus 1 gives 0 with only Z set. A byte subtract giving low bits 0xFE sets N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; captures result and flags |
| op_code | input | 3 | Operation select |
| width_code | input | 3 | Width and extension select |
| imm_sel | input | 1 | 1 selects the immediate as operand B |
| src_a | input | 32 | Register operand A |
| src_b | input | 32 | Register operand B |
| imm_val | input | 16 | Instruction immediate |
| result_q | output | 32 | Registered, extended result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry or borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The hardest cases to reach are the ones where the narrow-width flags differ from what a 32-bit view would give. Examples are a halfword add whose carry and overflow come out of bit 15 while the full-width sum is non-zero, and a byte subtract whose borrow depends only on the low bytes. The stimulus puts non-zero junk in the upper operand bits on purpose, so that a design computing at 32 bits would show wrong Z, C or V. It also compares the same byte result under zero and sign extension to separate N from the extension mode.

// File: rtl/narrow_alu_pkg.sv
package narrow_alu_pkg;

    parameter int DATA_W = 32;
    parameter int IMM_W  = 16;
    parameter int HALF_W = DATA_W / 2;
    parameter int BYTE_W = 8;

    typedef enum logic [2:0] {
        WD_WORD  = 3'd0,
        WD_HALFZ = 3'd1,
        WD_HALFS = 3'd2,
        WD_BYTEZ = 3'd3,
        WD_BYTES = 3'd4
    } width_e;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_SUB   = 3'd1,
        OP_AND   = 3'd2,
        OP_OR    = 3'd3,
        OP_XOR   = 3'd4,
        OP_PASSA = 3'd5
    } op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;

    function automatic width_e to_width(input logic [2:0] raw);
        case (raw)
            3'd1:    return WD_HALFZ;
            3'd2:    return WD_HALFS;
            3'd3:    return WD_BYTEZ;
            3'd4:    return WD_BYTES;
            default: return WD_WORD;
        endcase
    endfunction

    function automatic op_e to_op(input logic [2:0] raw);
        case (raw)
            3'd0:    return OP_ADD;
            3'd1:    return OP_SUB;
            3'd2:    return OP_AND;
            3'd3:    return OP_OR;
            3'd4:    return OP_XOR;
            default: return OP_PASSA;
        endcase
    endfunction

    // Bit index of the sign position for a width.
    function automatic int sign_pos(input width_e w);
        case (w)
            WD_HALFZ, WD_HALFS: return HALF_W - 1;
            WD_BYTEZ, WD_BYTES: return BYTE_W - 1;
            default:            return DATA_W - 1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] span_mask(input width_e w);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W; i++)
            m[i] = (i <= sign_pos(w));
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] fit_result(input logic [DATA_W-1:0] v,
                                                     input width_e w);
        logic [DATA_W-1:0] m;
        m = span_mask(w);
        if ((w == WD_HALFS || w == WD_BYTES) && v[sign_pos(w)])
            return (v & m) | ~m;
        return v & m;
    endfunction

endpackage

// File: rtl/narrow_alu_opsel.sv
module narrow_alu_opsel
    import narrow_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          imm_sel,
    input  logic [DW-1:0] reg_b,
    input  logic [IW-1:0] imm,
    output logic [DW-1:0] opnd_b
);
    localparam int EXT_W = DW - IW;

    logic [DW-1:0] imm_ext;

    assign imm_ext = {{EXT_W{imm[IW-1]}}, imm};
    assign opnd_b  = imm_sel ? imm_ext : reg_b;

endmodule

// File: rtl/narrow_alu_core.sv
module narrow_alu_core
    import narrow_alu_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  op_e           op,
    input  width_e        wsel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res_ext,
    output flags_t        flg
);
    logic [DW-1:0] mask, a_m, b_m, res;
    logic [DW:0]   sum;
    int            sp;
    logic          cy, ov;

    always_comb begin
        mask = span_mask(wsel);
        sp   = sign_pos(wsel);
        a_m  = a & mask;
        b_m  = b & mask;
        sum  = '0;
        cy   = 1'b0;
        ov   = 1'b0;
        case (op)
            OP_ADD: begin
                sum = {1'b0, a_m} + {1'b0, b_m};
                res = sum[DW-1:0] & mask;
                cy  = sum[sp+1];
                ov  = (a_m[sp] == b_m[sp]) && (res[sp] != a_m[sp]);
            end
            OP_SUB: begin
                sum = {1'b0, a_m} + {1'b0, ~b_m & mask} + (DW+1)'(1);
                res = sum[DW-1:0] & mask;
                cy  = ~sum[sp+1];
                ov  = (a_m[sp] != b_m[sp]) && (res[sp] != a_m[sp]);
            end
            OP_AND:  res = a_m & b_m;
            OP_OR:   res = a_m | b_m;
            OP_XOR:  res = a_m ^ b_m;
            default: res = a_m;
        endcase
        res_ext = fit_result(res, wsel);
        flg.z   = (res == '0);
        flg.n   = res[sp];
        flg.c   = cy;
        flg.v   = ov;
    end

endmodule

// File: rtl/narrow_alu.sv
module narrow_alu
    import narrow_alu_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = IMM_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exec_en,
    input  logic [2:0]    op_code,
    input  logic [2:0]    width_code,
    input  logic          imm_sel,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    input  logic [IW-1:0] imm_val,
    output logic [DW-1:0] result_q,
    output logic          flag_z,
    output logic          flag_n,
    output logic          flag_c,
    output logic          flag_v
);
    logic [DW-1:0] opnd_b, res_c;
    flags_t        flg_c, flg_q;
    op_e           op_dec;
    width_e        w_dec;

    assign op_dec = to_op(op_code);
    assign w_dec  = to_width(width_code);

    narrow_alu_opsel #(.DW(DW), .IW(IW)) u_opsel (
        .imm_sel (imm_sel),
        .reg_b   (src_b),
        .imm     (imm_val),
        .opnd_b  (opnd_b)
    );

    narrow_alu_core #(.DW(DW)) u_core (
        .op      (op_dec),
        .wsel    (w_dec),
        .a       (src_a),
        .b       (opnd_b),
        .res_ext (res_c),
        .flg     (flg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            flg_q    <= '0;
        end else if (exec_en) begin
            result_q <= res_c;
            flg_q    <= flg_c;
        end
    end

    assign flag_z = flg_q.z;
    assign flag_n = flg_q.n;
    assign flag_c = flg_q.c;
    assign flag_v = flg_q.v;

    // R2
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(result_q) && $stable(flg_q));

    // R7
    zero_match_chk: assert property (@(posedge clk) disable iff (rst)
        exec_en |=> (flag_z == (result_q == '0)));

    // R9
    logic_no_cv_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && op_code >= 3'd2) |=> (!flag_c && !flag_v));

    // R4
    byte_zext_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && width_code == 3'd3) |=> (result_q[DW-1:BYTE_W] == '0));

    // R4
    byte_sext_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && width_code == 3'd4) |=>
            (result_q[DW-1:BYTE_W] == {(DW-BYTE_W){result_q[BYTE_W-1]}}));

    // R7
    byte_neg_chk: assert property (@(posedge clk) disable iff (rst)
        (exec_en && (width_code == 3'd3 || width_code == 3'd4)) |=>
            (flag_n == result_q[BYTE_W-1]));

endmodule

// File: tb/narrow_alu_tb_top.sv
module narrow_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        exec_en;
    logic [2:0]  op_code, width_code;
    logic        imm_sel;
    logic [31:0] src_a, src_b;
    logic [15:0] imm_val;
    logic [31:0] result_q;
    logic        flag_z, flag_n, flag_c, flag_v;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    narrow_alu dut_i (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_code(op_code),
        .width_code(width_code), .imm_sel(imm_sel), .src_a(src_a),
        .src_b(src_b), .imm_val(imm_val), .result_q(result_q),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic expect_out(input string tag, input logic [31:0] er,
                              input logic [3:0] ef);
        logic [3:0] af;
        af = {flag_z, flag_n, flag_c, flag_v};
        n_run++;
        if (result_q !== er || af !== ef) begin
            n_fail++;
            $display("FAIL %s: result=%h zncv=%b expected result=%h zncv=%b",
                     tag, result_q, af, er, ef);
        end
    endtask

    // Drive at negedge, capture on posedge, sample at next negedge.
    task automatic run_op(input logic [2:0] op, input logic [2:0] w,
                          input logic isel, input logic [31:0] a,
                          input logic [31:0] b, input logic [15:0] imm);
        @(negedge clk);
        op_code = op; width_code = w; imm_sel = isel;
        src_a = a; src_b = b; imm_val = imm; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
    endtask

    task automatic t_reset;
        expect_out("R1 reset state", 32'h0, 4'b0000);
    endtask

    task automatic t_byte_sub;
        run_op(3'd1, 3'd3, 1'b1, 32'h0000_0001, 32'h0, 16'h0001);
        expect_out("R10 byte 1-1", 32'h0, 4'b1000);
        run_op(3'd1, 3'd4, 1'b0, 32'h0000_1200, 32'hABCD_0002, 16'h0);
        expect_out("R10 R4 sb 0-2", 32'hFFFF_FFFE, 4'b0110);
        run_op(3'd1, 3'd3, 1'b0, 32'h0000_1200, 32'hABCD_0002, 16'h0);
        expect_out("R7 b 0-2 zext keeps N", 32'h0000_00FE, 4'b0110);
        run_op(3'd1, 3'd4, 1'b0, 32'h0000_0080, 32'h0000_0001, 16'h0);
        expect_out("R8 sb 0x80-1 overflow", 32'h0000_007F, 4'b0001);
    endtask

    task automatic t_word_add;
        run_op(3'd0, 3'd0, 1'b0, 32'h7FFF_FFFF, 32'h1, 16'h0);
        expect_out("R8 word add overflow", 32'h8000_0000, 4'b0101);
        run_op(3'd0, 3'd0, 1'b0, 32'hFFFF_FFFF, 32'h1, 16'h0);
        expect_out("R8 word add carry", 32'h0, 4'b1010);
        run_op(3'd0, 3'd7, 1'b0, 32'hFFFF_0000, 32'h0001_0000, 16'h0);
        expect_out("R3 code 7 acts as word", 32'h0, 4'b1010);
    endtask

    task automatic t_half;
        run_op(3'd0, 3'd1, 1'b0, 32'hABCD_8000, 32'h0001_8000, 16'h0);
        expect_out("R4 R8 half add at bit 15", 32'h0, 4'b1011);
        run_op(3'd0, 3'd2, 1'b1, 32'h0000_7FFF, 32'h0, 16'h0001);
        expect_out("R4 sh add sign-extends", 32'hFFFF_8000, 4'b0101);
    endtask

    task automatic t_logic;
        run_op(3'd2, 3'd0, 1'b0, 32'hF0F0_1234, 32'h0FF0_FFFF, 16'h0);
        expect_out("R5 word AND", 32'h00F0_1234, 4'b0000);
        run_op(3'd3, 3'd4, 1'b0, 32'h5555_5580, 32'h0000_0001, 16'h0);
        expect_out("R9 sb OR", 32'hFFFF_FF81, 4'b0100);
        run_op(3'd4, 3'd1, 1'b0, 32'h9999_1234, 32'h0000_1234, 16'h0);
        expect_out("R5 half XOR zero", 32'h0, 4'b1000);
        run_op(3'd6, 3'd3, 1'b0, 32'h1234_56C3, 32'hFFFF_FFFF, 16'h0);
        expect_out("R5 reserved op passes A", 32'h0000_00C3, 4'b0100);
    endtask

    task automatic t_immediate;
        run_op(3'd0, 3'd0, 1'b1, 32'h1, 32'h5, 16'hFFFF);
        expect_out("R6 imm sign-extended", 32'h0, 4'b1010);
        run_op(3'd0, 3'd0, 1'b0, 32'h1, 32'h5, 16'hFFFF);
        expect_out("R6 imm ignored when reg", 32'h6, 4'b0000);
    endtask

    task automatic t_hold;
        run_op(3'd0, 3'd0, 1'b0, 32'h10, 32'h20, 16'h0);
        @(negedge clk);
        op_code = 3'd1; src_a = 32'h0; src_b = 32'h1; exec_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        expect_out("R2 hold without strobe", 32'h30, 4'b0000);
    endtask

    initial begin
        rst = 1'b1; exec_en = 1'b0; op_code = '0; width_code = '0;
        imm_sel = 1'b0; src_a = '0; src_b = '0; imm_val = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_byte_sub();
        t_word_add();
        t_half();
        t_logic();
        t_immediate();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule